// File: doc/BRIEF.md
# First-Order Delta-Sigma Pulse DAC

This block converts an unsigned digital code into a one-bit pulse stream. The density of ones in the stream matches the code. An external RC low-pass filter averages the stream into a voltage between ground and the I/O supply. The modulator is first order. On every rising clock edge it adds the code, minus a feedback term, to a running sum. The top bit of that sum gives the next pulse.

The accumulator is two bits wider than the code, so its top two bits act as a guard band. Feedback is taken from the sum's top bit: it subtracts one full-scale step whenever the previous pulse was high. Reset places the sum at the exact point that a zero code holds steady. A stream that starts from a zero code therefore begins with no stray pulse.

The code should come from a register clocked by the same clock. For full resolution, the code should change only every 2^DW cycles, so that each value is averaged over a complete window.

Top module: `sd_dac1`

## Requirements
- R1: Synchronous reset puts the block in its zero-code state. The pulse output reads 0, and the running sum holds 2^DW, which means its top two bits are 01 and the low DW bits are zero.
- R2: Reset takes priority over an accumulation step that falls in the same cycle. A reset asserted while a nonzero code is applied still leaves the pulse at 0 on the next cycle. The following zero-code window contains no ones.
- R3: A zero code held from reset produces no pulse at all.
- R4: The running sum never wraps: its top two bits are always 01 or 10. As a result, a full-scale code of 2^DW-1 held for several windows yields at least 2^DW-2 ones per window.
- R5: In the first aligned window after reset, with a constant code c, the number of ones is c or c-1 and never more than c.
- R6: In any aligned 2^DW-cycle window with a constant code c, after any earlier history, the number of ones is within one of c.
- R7: Over k consecutive aligned windows with the same code c, the total number of ones is within one of k*c.
- R8: When the pulse is high and the code applied at the next edge is zero, the pulse is low after that edge.
- R9: The code is sampled on the rising edge. The pulse comes from a flip-flop, so it changes only on a rising edge. The ones in a window are the pulse values seen before each of the window's 2^DW edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. All state updates on the rising edge. |
| rst_i | input | 1 | Synchronous reset, active high. |
| code_i | input | DW | Unsigned code to convert, sampled on the rising edge. |
| pulse_o | output | 1 | Registered pulse stream for the external filter. |

## Verification
Two things can fall in the same cycle: a reset and an accumulation step with a nonzero code. The bench provokes this by raising reset in the middle of a full-scale window without removing the code. It then expects a low pulse on the next cycle and a zero-code window with no ones. The code step and the feedback subtraction also meet at every window boundary. Sweeps that climb and fall through every code of a 4-bit instance judge those boundaries by the within-one count in each window. The bench computes the expected counts directly from the code.

// File: rtl/sd_dac1_pkg.sv
package sd_dac1_pkg;
   // running sum carries two guard bits above the code
   function automatic int acc_width(input int dw);
      return dw + 2;
   endfunction

   // number of clocks in one full-resolution window
   function automatic longint window_len(input int dw);
      return longint'(1) << dw;
   endfunction
endpackage

// File: rtl/sd_dac1_delta.sv
module sd_dac1_delta #(
   parameter int DW = 8,
   parameter int AW = DW + 2
) (
   input  logic [DW-1:0] code_i,
   input  logic          fb_i,
   output logic [AW-1:0] delta_o
);
   // feedback copies the previous top bit into both guard positions,
   // i.e. subtracts one full-scale step modulo 2^AW when it is set
   always_comb begin
      delta_o = {{(AW-DW){fb_i}}, code_i};
   end
endmodule

// File: rtl/sd_dac1_sigma.sv
module sd_dac1_sigma #(
   parameter int DW = 8,
   parameter int AW = DW + 2
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [AW-1:0] delta_i,
   output logic [AW-1:0] acc_q,
   output logic [AW-1:0] acc_d
);
   localparam logic [AW-1:0] ACC_ZERO = {2'b01, {DW{1'b0}}};

   always_comb begin
      acc_d = acc_q + delta_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) acc_q <= ACC_ZERO;
      else       acc_q <= acc_d;
   end
endmodule

// File: rtl/sd_dac1_outreg.sv
module sd_dac1_outreg (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bit_d,
   output logic bit_q
);
   always_ff @(posedge clk_i) begin
      if (rst_i) bit_q <= 1'b0;
      else       bit_q <= bit_d;
   end
endmodule

// File: rtl/sd_dac1.sv
module sd_dac1 #(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [DW-1:0] code_i,
   output logic          pulse_o
);
   import sd_dac1_pkg::*;

   localparam int AW = acc_width(DW);

   if (DW < 2 || DW > 24) begin : g_bad_dw
      $error("sd_dac1: DW must lie in 2..24");
   end

   logic [AW-1:0] delta;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] acc_d;

   sd_dac1_delta #(.DW(DW), .AW(AW)) u_delta (
      .code_i  (code_i),
      .fb_i    (acc_q[AW-1]),
      .delta_o (delta)
   );

   sd_dac1_sigma #(.DW(DW), .AW(AW)) u_sigma (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .delta_i (delta),
      .acc_q   (acc_q),
      .acc_d   (acc_d)
   );

   sd_dac1_outreg u_out (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .bit_d (acc_d[AW-1]),
      .bit_q (pulse_o)
   );
endmodule

// File: rtl/sd_dac1_chk.sv
module sd_dac1_chk #(
   parameter int DW = 8
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic [DW-1:0] code_i,
   input logic          pulse_o,
   input logic [DW+1:0] acc_q
);
   localparam int AW = DW + 2;
   localparam logic [AW-1:0] ACC_ZERO = {2'b01, {DW{1'b0}}};

   assert_reset_state_R1: assert property (@(posedge clk_i)
      rst_i |=> (!pulse_o && acc_q == ACC_ZERO))
      else $error("R1 reset state wrong");

   assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      acc_q[AW-1] != acc_q[AW-2])
      else $error("R4 running sum left guard band");

   assert_zero_silent_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pulse_o && code_i == '0) |=> !pulse_o)
      else $error("R3 pulse from zero code");

   assert_zero_drains_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_o && code_i == '0) |=> !pulse_o)
      else $error("R8 pulse held on zero code");
endmodule

bind sd_dac1 sd_dac1_chk #(.DW(DW)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .code_i  (code_i),
   .pulse_o (pulse_o),
   .acc_q   (acc_q)
);

// File: tb/sd_dac1_bench.sv
`timescale 1ns/1ps
module sd_dac1_bench;
   localparam int DW  = 4;
   localparam int WIN = 1 << DW;
   localparam int MAXC = WIN - 1;

   logic          clk_i = 1'b0;
   logic          rst_i = 1'b1;
   logic [DW-1:0] code_i = '0;
   logic          pulse_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk_i = ~clk_i;   // 200 MHz

   sd_dac1 #(.DW(DW)) u_sd_dac1 (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .code_i  (code_i),
      .pulse_o (pulse_o)
   );

   task automatic check_rng(input string tag, input int got, input int lo, input int hi);
      n_chk++;
      if (got < lo || got > hi) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
      end
   endtask

   // called at a negedge; leaves the bench at a negedge
   task automatic do_reset();
      rst_i = 1'b1;
      @(negedge clk_i);
      @(negedge clk_i);
      check_rng("R1 pulse after reset", int'(pulse_o), 0, 0);
      rst_i = 1'b0;
   endtask

   // R9: count pulse before each of the window's edges
   task automatic run_window(input int c, output int ones);
      ones = 0;
      code_i = DW'(c);
      for (int i = 0; i < WIN; i++) begin
         ones += int'(pulse_o);
         @(negedge clk_i);
      end
   endtask

   initial begin
      int ones;
      int total;
      @(negedge clk_i);
      do_reset();

      // R3: zero code straight after reset
      run_window(0, ones);
      check_rng("R3 zero code window", ones, 0, 0);

      // R5: every code from a fresh reset
      for (int c = 0; c < WIN; c++) begin
         do_reset();
         run_window(c, ones);
         check_rng($sformatf("R5 first window code %0d", c), ones, (c > 0) ? c - 1 : 0, c);
      end

      // R6: rising then falling sweep without reset
      do_reset();
      for (int c = 0; c < WIN; c++) begin
         run_window(c, ones);
         check_rng($sformatf("R6 up code %0d", c), ones, c - 1, c + 1);
      end
      for (int c = MAXC; c >= 0; c--) begin
         run_window(c, ones);
         check_rng($sformatf("R6 down code %0d", c), ones, c - 1, c + 1);
      end
      // R6: alternating extremes
      for (int k = 0; k < 4; k++) begin
         run_window(MAXC - k, ones);
         check_rng("R6 alt high", ones, MAXC - k - 1, MAXC - k + 1);
         run_window(k + 1, ones);
         check_rng("R6 alt low", ones, k, k + 2);
      end

      // R7: cumulative count over several windows
      for (int c = 1; c < WIN; c += 3) begin
         total = 0;
         for (int k = 0; k < 5; k++) begin
            run_window(c, ones);
            total += ones;
         end
         check_rng($sformatf("R7 five windows code %0d", c), total, 5 * c - 1, 5 * c + 1);
      end

      // R4: full scale held long, no wrap
      for (int k = 0; k < 4; k++) begin
         run_window(MAXC, ones);
         check_rng("R4 full scale window", ones, MAXC - 1, MAXC);
      end

      // R8: pulse high, then zero code at next edge
      code_i = DW'(MAXC);
      while (pulse_o !== 1'b1) @(negedge clk_i);
      code_i = '0;
      @(negedge clk_i);
      check_rng("R8 pulse after zero code", int'(pulse_o), 0, 0);

      // R2: reset together with a full-scale accumulation step
      code_i = DW'(MAXC);
      for (int i = 0; i < 5; i++) @(negedge clk_i);
      while (pulse_o !== 1'b1) @(negedge clk_i);
      rst_i = 1'b1;
      @(negedge clk_i);
      check_rng("R2 pulse after reset over code", int'(pulse_o), 0, 0);
      rst_i = 1'b0;
      run_window(0, ones);
      check_rng("R2 zero window after reset", ones, 0, 0);

      // R9: pulse holds between edges
      code_i = DW'(7);
      @(negedge clk_i);
      ones = int'(pulse_o);
      #1.0;
      check_rng("R9 pulse stable off-edge", int'(pulse_o), ones, ones);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule